// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This block takes one 32-bit single-precision operand per cycle and returns its 16-bit half-precision equivalent two cycles later. The half result has 1 sign bit, a 5-bit exponent with a bias of 15, and 10 stored fraction bits. The conversion rounds to nearest, with ties going to the even result. Results too small for a normal half value come out as subnormals or as signed zero. Results too large come out as infinity. NaN and infinity are carried over as their half counterparts. Three flags travel with each result: overflow, underflow and inexact.

A second range mode is selected per operand through `sat_mode_i`. In this mode the top exponent code is an ordinary normal exponent, so the largest magnitude becomes 131008. There is no infinity code in this mode: overflow and infinite inputs clamp to that maximum, and NaN becomes a zero with the input's sign. The parameter `ALT_EN` controls whether the mode is built at all. With `ALT_EN` at 0 the mode input is ignored.

The reset is asynchronous and active low. It is expected to be released in step with `clk`.

Top module: `sp2hp_narrow`

## Requirements
- R1: A finite input whose value fits exactly in half precision converts with no flag raised (1.0 = 0x3F800000 gives 0x3C00, -2.0 = 0xC0000000 gives 0xC000). The result is sign in bit 15, biased exponent in bits 14:10 and fraction in bits 9:0.
- R2: Discarded bits worth less than half a unit in the last place are dropped and set inexact (0x3EAAAAAB gives 0x3555, inexact).
- R3: Discarded bits worth exactly half a unit round toward the even fraction (0x3F801000 gives 0x3C00, 0x3F803000 gives 0x3C02, both inexact).
- R4: Discarded bits worth more than half a unit round up (0x3F801001 gives 0x3C01, inexact).
- R5: A carry out of an all-ones fraction during rounding raises the exponent by one and clears the fraction (0x3FFFF000 gives 0x4000).
- R6: Magnitudes below 2^-14 come out with exponent field 0 as subnormals. Exact ones raise no flag (2^-24 gives 0x0001, 2^-20 gives 0x0010, 0x387FC000 gives 0x03FF).
- R7: A subnormal that rounds up past the largest subnormal becomes the smallest normal 0x0400. Underflow stays clear because the exponent field is nonzero (0x387FF000 gives 0x0400, inexact only).
- R8: A result with exponent field 0 that is also inexact raises underflow and inexact. Tiny inputs flush to signed zero, with exact half-way ties going to zero (2^-26 and 2^-25 give 0x0000, 1.5*2^-25 gives 0x0001, 0xB2800000 gives 0x8000, the single subnormal 0x00000001 gives 0x0000). A zero input gives signed zero with no flag.
- R9: In the IEEE mode (`sat_mode_i`=0), 65504 (0x477FE000) gives 0x7BFF with no flag. A rounded magnitude above it gives signed infinity 0x7C00 or 0xFC00 with overflow and inexact (0x477FF000, 0x501502F9, 0xC77FF000).
- R10: In the IEEE mode, infinity gives signed 0x7C00 and any NaN gives the quiet code 0x7E00 with the input's sign, with no flag raised.
- R11: In the second mode (`sat_mode_i`=1), exponent 31 holds normal values. 0x477FF000 gives 0x7C00 (65536, inexact only), and 131008 (0x47FFE000) gives 0x7FFF exactly. Larger magnitudes and infinity clamp to 0x7FFF with their sign and raise overflow and inexact. NaN gives signed zero with no flag.
- R12: Each result and its flags appear exactly two rising edges after the operand is sampled with `in_valid_i`, with `out_valid_o` high for exactly that cycle. Back-to-back operands, each with its own mode, are accepted every cycle. Asserting `rst_n` low at once clears `out_valid_o` and all three flags and drops the operands in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand on `op_i` is valid this cycle |
| sat_mode_i | input | 1 | 1 selects the clamping second range mode for this operand |
| op_i | input | 32 | Single-precision operand |
| out_valid_o | output | 1 | Result and flags are valid this cycle |
| res_o | output | 16 | Half-precision result |
| ovf_o | output | 1 | Overflow: result became infinity or was clamped |
| unf_o | output | 1 | Underflow: tiny (exponent field 0) and inexact |
| inx_o | output | 1 | Inexact: the result differs from the operand |

## Verification
The bench builds the block with its default parameters: 8/23 source fields, 5/10 destination fields and `ALT_EN`=1. These settings make both range modes reachable, and also the full alignment shifter, from zero shift through the flush-to-zero cap. The directed operands target the bit patterns where rounding turns over: exact ties on odd and even fractions, the carry from an all-ones fraction, the carry from the largest subnormal, and the edge values on both sides of each mode's maximum. The mode is switched between back-to-back operands, which shows that it travels down the pipeline with its own operand.

// File: rtl/hpconv_pkg.sv
package hpconv_pkg;

  // Coarse class of the source operand; finite covers zero, subnormal and normal.
  typedef enum logic [1:0] {
    KIND_FINITE = 2'd0,
    KIND_INF    = 2'd1,
    KIND_NAN    = 2'd2
  } kind_e;

endpackage

// File: rtl/hpconv_unpack.sv
module hpconv_unpack
  import hpconv_pkg::*;
#(
  parameter int SEW = 8,
  parameter int SFW = 23,
  parameter int DEW = 5,
  parameter int DFW = 10,
  localparam int XW = SEW + 2,
  localparam int SH_CAP = DFW + 2,
  localparam int SH_W = $clog2(SH_CAP + 1)
) (
  input  logic [SEW+SFW:0]  op_i,
  output kind_e             kind_o,
  output logic              sign_o,
  output logic [SFW:0]      sig_o,
  output logic [SH_W-1:0]   shamt_o,
  output logic [XW-1:0]     base_exp_o
);

  localparam int SRC_BIAS = (1 << (SEW - 1)) - 1;
  localparam int DST_BIAS = (1 << (DEW - 1)) - 1;

  logic [SEW-1:0]        exp_f;
  logic [SFW-1:0]        frc_f;
  logic signed [XW-1:0]  dexp;
  logic signed [XW-1:0]  sh_full;
  logic                  tiny;

  assign exp_f = op_i[SEW+SFW-1:SFW];
  assign frc_f = op_i[SFW-1:0];
  assign sign_o = op_i[SEW+SFW];

  always_comb begin
    if (&exp_f) kind_o = (|frc_f) ? KIND_NAN : KIND_INF;
    else        kind_o = KIND_FINITE;
  end

  // The hidden one is present only for normal sources; source subnormals
  // then fall through the tiny path with a capped shift.
  assign sig_o = {|exp_f, frc_f};

  // Rebias into the destination exponent range.
  assign dexp    = $signed({2'b00, exp_f}) - $signed(XW'(SRC_BIAS - DST_BIAS));
  assign tiny    = (dexp < $signed(XW'(1)));
  assign sh_full = $signed(XW'(1)) - dexp;

  always_comb begin
    if (!tiny)                               shamt_o = '0;
    else if (sh_full > $signed(XW'(SH_CAP))) shamt_o = SH_W'(SH_CAP);
    else                                     shamt_o = sh_full[SH_W-1:0];
  end

  // Exponent one below the final value; the rounded significand's top two
  // bits are added back in the rounding stage.
  assign base_exp_o = tiny ? '0 : XW'(dexp - $signed(XW'(1)));

endmodule

// File: rtl/hpconv_align.sv
module hpconv_align #(
  parameter int SFW = 23,
  parameter int DFW = 10,
  localparam int SH_CAP = DFW + 2,
  localparam int SH_W = $clog2(SH_CAP + 1)
) (
  input  logic [SFW:0]     sig_i,
  input  logic [SH_W-1:0]  shamt_i,
  output logic [DFW:0]     keep_o,
  output logic             guard_o,
  output logic             sticky_o
);

  // Padding as wide as the largest shift, so no set bit can leave the vector.
  localparam int EW = SFW + 1 + SH_CAP;

  logic [EW-1:0] ext;
  logic [EW-1:0] shv;

  assign ext      = {sig_i, {SH_CAP{1'b0}}};
  assign shv      = ext >> shamt_i;
  assign keep_o   = shv[EW-1 -: DFW+1];
  assign guard_o  = shv[EW-DFW-2];
  assign sticky_o = |shv[EW-DFW-3:0];

endmodule

// File: rtl/hpconv_round.sv
module hpconv_round
  import hpconv_pkg::*;
#(
  parameter int DEW = 5,
  parameter int DFW = 10,
  parameter int XW  = 10
) (
  input  kind_e                kind_i,
  input  logic                 sign_i,
  input  logic                 alt_i,
  input  logic [DFW:0]         keep_i,
  input  logic                 guard_i,
  input  logic                 sticky_i,
  input  logic signed [XW-1:0] base_exp_i,
  output logic [DEW+DFW:0]     res_o,
  output logic                 ovf_o,
  output logic                 unf_o,
  output logic                 inx_o
);

  localparam int EMAX_IEEE = (1 << DEW) - 2;
  localparam int EMAX_ALT  = (1 << DEW) - 1;
  localparam logic [DEW+DFW-1:0] MAG_INF  = {{DEW{1'b1}}, {DFW{1'b0}}};
  localparam logic [DEW+DFW-1:0] MAG_SAT  = {(DEW+DFW){1'b1}};
  localparam logic [DEW+DFW-1:0] MAG_QNAN = {{DEW{1'b1}}, 1'b1, {(DFW-1){1'b0}}};

  logic                  inc;
  logic                  lost;
  logic [DFW+1:0]        sum;
  logic signed [XW-1:0]  rexp;
  logic signed [XW-1:0]  emax;
  logic                  too_big;
  logic [DEW+DFW-1:0]    mag;

  assign lost = guard_i | sticky_i;
  assign inc  = guard_i & (sticky_i | keep_i[0]);
  assign sum  = {1'b0, keep_i} + (DFW+2)'(inc);

  // Top two significand bits: 00/01 on the tiny path, 01/10 on the normal path.
  assign rexp    = base_exp_i + $signed({{(XW-2){1'b0}}, sum[DFW+1:DFW]});
  assign emax    = alt_i ? $signed(XW'(EMAX_ALT)) : $signed(XW'(EMAX_IEEE));
  assign too_big = (rexp > emax);

  always_comb begin
    mag   = '0;
    ovf_o = 1'b0;
    unf_o = 1'b0;
    inx_o = 1'b0;
    case (kind_i)
      KIND_NAN: mag = alt_i ? '0 : MAG_QNAN;
      KIND_INF: begin
        if (alt_i) begin
          mag   = MAG_SAT;
          ovf_o = 1'b1;
          inx_o = 1'b1;
        end else begin
          mag = MAG_INF;
        end
      end
      default: begin
        if (too_big) begin
          mag   = alt_i ? MAG_SAT : MAG_INF;
          ovf_o = 1'b1;
          inx_o = 1'b1;
        end else begin
          mag   = {rexp[DEW-1:0], sum[DFW-1:0]};
          inx_o = lost;
          unf_o = lost & (rexp == '0);
        end
      end
    endcase
  end

  assign res_o = {sign_i, mag};

endmodule

// File: rtl/sp2hp_narrow.sv
module sp2hp_narrow
  import hpconv_pkg::*;
#(
  parameter int SRC_EXP_W = 8,
  parameter int SRC_FRC_W = 23,
  parameter int DST_EXP_W = 5,
  parameter int DST_FRC_W = 10,
  parameter bit ALT_EN    = 1'b1,
  localparam int SRC_W = 1 + SRC_EXP_W + SRC_FRC_W,
  localparam int DST_W = 1 + DST_EXP_W + DST_FRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic             sat_mode_i,
  input  logic [SRC_W-1:0] op_i,
  output logic             out_valid_o,
  output logic [DST_W-1:0] res_o,
  output logic             ovf_o,
  output logic             unf_o,
  output logic             inx_o
);

  localparam int XW     = SRC_EXP_W + 2;
  localparam int SH_CAP = DST_FRC_W + 2;
  localparam int SH_W   = $clog2(SH_CAP + 1);

  typedef struct packed {
    kind_e                kind;
    logic                 sign;
    logic                 alt;
    logic [DST_FRC_W:0]   keep;
    logic                 grd;
    logic                 stk;
    logic [XW-1:0]        bexp;
  } stage1_t;

  typedef struct packed {
    logic [DST_W-1:0] res;
    logic             ovf;
    logic             unf;
    logic             inx;
  } stage2_t;

  // ---------------- stage 1: unpack and align ----------------
  logic               alt_w;
  kind_e              up_kind;
  logic               up_sign;
  logic [SRC_FRC_W:0] up_sig;
  logic [SH_W-1:0]    up_sh;
  logic [XW-1:0]      up_bexp;
  logic [DST_FRC_W:0] al_keep;
  logic               al_grd;
  logic               al_stk;

  if (ALT_EN) begin : g_alt_on
    assign alt_w = sat_mode_i;
  end else begin : g_alt_off
    assign alt_w = 1'b0;
  end

  hpconv_unpack #(
    .SEW(SRC_EXP_W), .SFW(SRC_FRC_W), .DEW(DST_EXP_W), .DFW(DST_FRC_W)
  ) u_unpack (
    .op_i      (op_i),
    .kind_o    (up_kind),
    .sign_o    (up_sign),
    .sig_o     (up_sig),
    .shamt_o   (up_sh),
    .base_exp_o(up_bexp)
  );

  hpconv_align #(
    .SFW(SRC_FRC_W), .DFW(DST_FRC_W)
  ) u_align (
    .sig_i   (up_sig),
    .shamt_i (up_sh),
    .keep_o  (al_keep),
    .guard_o (al_grd),
    .sticky_o(al_stk)
  );

  logic    s1_vld_d, s1_vld_q;
  stage1_t s1_d, s1_q;

  always_comb begin
    s1_vld_d = in_valid_i;
    s1_d     = s1_q;
    if (in_valid_i) begin
      s1_d.kind = up_kind;
      s1_d.sign = up_sign;
      s1_d.alt  = alt_w;
      s1_d.keep = al_keep;
      s1_d.grd  = al_grd;
      s1_d.stk  = al_stk;
      s1_d.bexp = up_bexp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_q     <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_q     <= s1_d;
    end
  end

  // ---------------- stage 2: round and pack ----------------
  logic [DST_W-1:0] rn_res;
  logic             rn_ovf, rn_unf, rn_inx;

  hpconv_round #(
    .DEW(DST_EXP_W), .DFW(DST_FRC_W), .XW(XW)
  ) u_round (
    .kind_i    (s1_q.kind),
    .sign_i    (s1_q.sign),
    .alt_i     (s1_q.alt),
    .keep_i    (s1_q.keep),
    .guard_i   (s1_q.grd),
    .sticky_i  (s1_q.stk),
    .base_exp_i($signed(s1_q.bexp)),
    .res_o     (rn_res),
    .ovf_o     (rn_ovf),
    .unf_o     (rn_unf),
    .inx_o     (rn_inx)
  );

  logic    s2_vld_d, s2_vld_q;
  stage2_t s2_d, s2_q;

  always_comb begin
    s2_vld_d = s1_vld_q;
    s2_d     = s2_q;
    if (s1_vld_q) begin
      s2_d.res = rn_res;
      s2_d.ovf = rn_ovf;
      s2_d.unf = rn_unf;
      s2_d.inx = rn_inx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld_q <= 1'b0;
      s2_q     <= '0;
    end else begin
      s2_vld_q <= s2_vld_d;
      s2_q     <= s2_d;
    end
  end

  assign out_valid_o = s2_vld_q;
  assign res_o       = s2_q.res;
  assign ovf_o       = s2_q.ovf;
  assign unf_o       = s2_q.unf;
  assign inx_o       = s2_q.inx;

endmodule

module sp2hp_narrow_chk #(
  parameter int DEW    = 5,
  parameter int DFW    = 10,
  parameter bit ALT_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid_i,
  input logic             sat_mode_i,
  input logic             out_valid_o,
  input logic [DEW+DFW:0] res_o,
  input logic             ovf_o,
  input logic             unf_o,
  input logic             inx_o
);

  localparam logic [DEW+DFW-1:0] MAG_INF = {{DEW{1'b1}}, {DFW{1'b0}}};
  localparam logic [DEW+DFW-1:0] MAG_SAT = {(DEW+DFW){1'b1}};

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid_i |=> ##1 out_valid_o);  // R12
  AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid_i |=> ##1 !out_valid_o);  // R12
  AST_UNF_TINY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && unf_o) |-> (inx_o && res_o[DEW+DFW-1:DFW] == '0));  // R8
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && ovf_o) |-> inx_o);  // R9
  AST_OVF_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && ovf_o && !(ALT_EN && $past(sat_mode_i, 2)))
      |-> (res_o[DEW+DFW-1:0] == MAG_INF));  // R9
  AST_OVF_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && ovf_o && ALT_EN && $past(sat_mode_i, 2))
      |-> (res_o[DEW+DFW-1:0] == MAG_SAT));  // R11

endmodule

bind sp2hp_narrow sp2hp_narrow_chk #(
  .DEW(DST_EXP_W), .DFW(DST_FRC_W), .ALT_EN(ALT_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid_i (in_valid_i),
  .sat_mode_i (sat_mode_i),
  .out_valid_o(out_valid_o),
  .res_o      (res_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o),
  .inx_o      (inx_o)
);

// File: tb/sp2hp_narrow_tb.sv
`timescale 1ns/1ps
module sp2hp_narrow_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic        mode;
  logic [31:0] op;
  logic        ovld;
  logic [15:0] res;
  logic        ovf, unf, inx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  sp2hp_narrow u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (vld),
    .sat_mode_i (mode),
    .op_i       (op),
    .out_valid_o(ovld),
    .res_o      (res),
    .ovf_o      (ovf),
    .unf_o      (unf),
    .inx_o      (inx)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_out(string tag, logic [15:0] er, logic [2:0] efl);
    check(tag, "out_valid", 32'(ovld), 32'd1);
    check(tag, "result", 32'(res), 32'(er));
    check(tag, "flags ovf/unf/inx", 32'({ovf, unf, inx}), 32'(efl));
  endtask

  // One operand alone: driven at a falling edge, checked two rising edges later.
  task automatic conv(string tag, logic [31:0] a, logic m, logic [15:0] er, logic [2:0] efl);
    @(negedge clk);
    op = a; mode = m; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    check_out(tag, er, efl);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; vld = 1'b0; mode = 1'b0; op = '0;
    repeat (3) @(negedge clk);
    check("R12", "reset out_valid", 32'(ovld), 32'd0);
    check("R12", "reset flags", 32'({ovf, unf, inx}), 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_exact();
    conv("R1", 32'h3F800000, 1'b0, 16'h3C00, 3'b000);
    conv("R1", 32'hC0000000, 1'b0, 16'hC000, 3'b000);
    conv("R1", 32'h00000000, 1'b0, 16'h0000, 3'b000);
  endtask

  task automatic t_round_nearest();
    conv("R2", 32'h3EAAAAAB, 1'b0, 16'h3555, 3'b001);
    conv("R4", 32'h3F801001, 1'b0, 16'h3C01, 3'b001);
  endtask

  task automatic t_ties();
    conv("R3", 32'h3F801000, 1'b0, 16'h3C00, 3'b001);
    conv("R3", 32'h3F803000, 1'b0, 16'h3C02, 3'b001);
  endtask

  task automatic t_carry();
    conv("R5", 32'h3FFFF000, 1'b0, 16'h4000, 3'b001);
    conv("R7", 32'h387FF000, 1'b0, 16'h0400, 3'b001);
  endtask

  task automatic t_subnormal();
    conv("R6", 32'h33800000, 1'b0, 16'h0001, 3'b000);
    conv("R6", 32'h35800000, 1'b0, 16'h0010, 3'b000);
    conv("R6", 32'h387FC000, 1'b0, 16'h03FF, 3'b000);
  endtask

  task automatic t_underflow();
    conv("R8", 32'h32800000, 1'b0, 16'h0000, 3'b011);
    conv("R8", 32'h33000000, 1'b0, 16'h0000, 3'b011);
    conv("R8", 32'h33400000, 1'b0, 16'h0001, 3'b011);
    conv("R8", 32'hB2800000, 1'b0, 16'h8000, 3'b011);
    conv("R8", 32'h00000001, 1'b0, 16'h0000, 3'b011);
    conv("R8", 32'h80000000, 1'b0, 16'h8000, 3'b000);
  endtask

  task automatic t_ieee_overflow();
    conv("R9", 32'h477FE000, 1'b0, 16'h7BFF, 3'b000);
    conv("R9", 32'h477FF000, 1'b0, 16'h7C00, 3'b101);
    conv("R9", 32'h501502F9, 1'b0, 16'h7C00, 3'b101);
    conv("R9", 32'hC77FF000, 1'b0, 16'hFC00, 3'b101);
  endtask

  task automatic t_specials();
    conv("R10", 32'h7F800000, 1'b0, 16'h7C00, 3'b000);
    conv("R10", 32'hFF800000, 1'b0, 16'hFC00, 3'b000);
    conv("R10", 32'hFFC00001, 1'b0, 16'hFE00, 3'b000);
    conv("R10", 32'h7F800001, 1'b0, 16'h7E00, 3'b000);
  endtask

  task automatic t_alt_mode();
    conv("R11", 32'h477FF000, 1'b1, 16'h7C00, 3'b001);
    conv("R11", 32'h47FFE000, 1'b1, 16'h7FFF, 3'b000);
    conv("R11", 32'h48000000, 1'b1, 16'h7FFF, 3'b101);
    conv("R11", 32'hFF800000, 1'b1, 16'hFFFF, 3'b101);
    conv("R11", 32'hFFC00000, 1'b1, 16'h8000, 3'b000);
    conv("R11", 32'h3EAAAAAB, 1'b1, 16'h3555, 3'b001);
  endtask

  task automatic t_pipeline();
    @(negedge clk);
    op = 32'h477FF000; mode = 1'b0; vld = 1'b1;
    @(negedge clk);
    op = 32'h477FF000; mode = 1'b1;
    check("R12", "idle before first result", 32'(ovld), 32'd0);
    @(negedge clk);
    check_out("R12", 16'h7C00, 3'b101);
    op = 32'h3F800000; mode = 1'b0;
    @(negedge clk);
    vld = 1'b0;
    check_out("R12", 16'h7C00, 3'b001);
    @(negedge clk);
    check_out("R12", 16'h3C00, 3'b000);
    @(negedge clk);
    check("R12", "valid drops after burst", 32'(ovld), 32'd0);
  endtask

  task automatic t_async_reset();
    conv("R12", 32'h477FF000, 1'b0, 16'h7C00, 3'b101);
    @(negedge clk);
    op = 32'h3F800000; mode = 1'b0; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R12", "async reset out_valid", 32'(ovld), 32'd0);
    check("R12", "async reset flags", 32'({ovf, unf, inx}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", "dropped op after reset", 32'(ovld), 32'd0);
    @(negedge clk);
    check("R12", "dropped op after reset", 32'(ovld), 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_exact();
    t_round_nearest();
    t_ties();
    t_carry();
    t_subnormal();
    t_underflow();
    t_ieee_overflow();
    t_specials();
    t_alt_mode();
    t_pipeline();
    t_async_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule